// File: doc/BRIEF.md
# Serial Control Register Slave for a Video Processor

This block is the two-wire serial slave of a video processor. It answers to one fixed 7-bit device address. A write transaction carries a subaddress byte followed by any number of data bytes. Each data byte lands in the control register the pointer names, and the pointer then advances by one. The control registers leave the block as one flat vector that the processing core decodes.

A read transaction always begins with status byte 0 and streams three status bytes. The core supplies most of the status bits. The block inserts two of them itself:
- a sticky power-up flag in the top bit of byte 0;
- a copy of the two crystal-selection bits of register 0x00, which lets software confirm that they arrived intact.

The block pulses a strobe once every one of the 27 control registers has been written since reset. The core can use that pulse to start its calibration.

The host first polls the status until the power-up flag reads 0. It then writes the whole register set. SCL and SDA arrive already filtered. They are resynchronised to the system clock. SDA is driven open-drain through an output enable.

Top module: `i2c_ctl_slave`

## Requirements
- R1: The slave acknowledges address bytes 0x8A (write) and 0x8B (read): the 7-bit address 1000101 followed by the R/W bit, where 1 means read. Any other address byte is not acknowledged and changes no register.
- R2: In a write, the first byte after the address is the subaddress. Each data byte is stored in the register the pointer names, and the pointer advances by one after every data byte. Register n appears on `ctrl_regs[8n+7:8n]`.
- R3: Data bytes aimed at a pointer above 0x1A, including 0xFE, are acknowledged and leave every register unchanged.
- R4: Every read starts at status byte 0. Byte 0 is {power flag, `core_stat0[6:0]`}. Byte 1 is {`core_stat1[5:0]`, bits 1:0 of register 0x00}. Byte 2 is `core_stat2`. Every byte after the third reads 0xFF.
- R5: The power flag reads 1 from reset until status byte 0 has been sent and acknowledged by the master. A byte 0 ended with NACK leaves the flag set.
- R6: `all_written` pulses high for exactly one clock when the last of the 27 registers (0x00..0x1A) receives its first write since reset. It does not pulse again before the next reset.
- R7: The slave pulls SDA low during the ninth clock of every byte it acknowledges and releases it after that clock. A stop condition leaves SDA released.
- R8: After reset, all registers read 0, SDA is released, `all_written` is low and the power flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Filtered serial clock line |
| sda_i | input | 1 | Filtered serial data line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| core_stat0 | input | 7 | Core status bits for status byte 0, bits 6:0 |
| core_stat1 | input | 6 | Core status bits for status byte 1, bits 7:2 |
| core_stat2 | input | 8 | Core status byte 2 |
| ctrl_regs | output | 216 | All 27 control registers, register n in bits 8n+7:8n |
| all_written | output | 1 | One-clock pulse when the register set is complete |

## Verification
Two things can fall into one write burst: the data byte that completes the register set, and the pointer running past 0x1A. The bench provokes this by leaving only register 0x1A unwritten. It then sends a burst of two bytes starting at 0x1A, so the second byte addresses 0x1B. The run is judged on three points: exactly one strobe pulse, 0x1A holding the first byte, and every other register still matching the bench's own model. A second collision occurs on reads. The power flag is cleared by the acknowledge of byte 0, but byte 0 has already been loaded with the flag still set. The bench therefore expects a 1 in the read that clears the flag and a 0 only in the next read.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK_WAIT,
    PH_ACK_DRIVE,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_SUB,
    BK_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;
  logic       scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
    end
  end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h45,
  parameter int         NUM_STAT = 3,
  localparam int        IDXW     = $clog2(NUM_STAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDXW-1:0]   rd_idx,
  output logic              rd_ack,
  output logic [IDXW-1:0]   ack_idx
);
  localparam logic [IDXW-1:0] IDX_SAT = IDXW'(NUM_STAT);

  phase_t            phase;
  byte_kind_t        kind;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, ptr;
  logic              rw;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sh[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      kind    <= BK_ADDR;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_idx  <= '0;
      rd_ack  <= 1'b0;
      ack_idx <= '0;
    end else begin
      wr_en  <= 1'b0;
      rd_ack <= 1'b0;
      if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        phase   <= PH_RX;
        kind    <= BK_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE: ;
          PH_RX: if (scl_rise) begin
            rx_sh   <= rx_next;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              unique case (kind)
                BK_ADDR: begin
                  if (rx_next[7:1] == DEV_ADDR) begin
                    rw     <= rx_next[0];
                    rd_idx <= '0;
                    phase  <= PH_ACK_WAIT;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                BK_SUB: begin
                  ptr   <= rx_next;
                  phase <= PH_ACK_WAIT;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_next;
                  ptr     <= ptr + 8'd1;
                  phase   <= PH_ACK_WAIT;
                end
              endcase
            end
          end
          PH_ACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            phase  <= PH_ACK_DRIVE;
          end
          PH_ACK_DRIVE: if (scl_fall) begin
            bit_cnt <= '0;
            if (kind == BK_ADDR && rw) begin
              tx_sh  <= tx_byte;
              sda_oe <= ~tx_byte[BYTE_W-1];
              phase  <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
              kind   <= (kind == BK_ADDR) ? BK_SUB : BK_DATA;
            end
          end
          PH_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              phase  <= PH_TX_ACK;
            end else begin
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~tx_sh[BYTE_W-2];
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                rd_ack  <= 1'b1;
                ack_idx <= rd_idx;
                if (rd_idx != IDX_SAT) rd_idx <= rd_idx + 1'b1;
              end else begin
                phase <= PH_IDLE;
              end
            end else if (scl_fall) begin
              tx_sh   <= tx_byte;
              sda_oe  <= ~tx_byte[BYTE_W-1];
              bit_cnt <= '0;
              phase   <= PH_TX;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R7: a stop condition always leaves the line released
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R1: a wrong device address never leads to a write strobe in the next cycle
  assert_foreign_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RX && kind == BK_ADDR && scl_rise && bit_cnt == 3'd7 &&
     rx_next[7:1] != DEV_ADDR) |=> (phase == PH_IDLE && !wr_en));
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import i2c_ctl_pkg::*;
#(
  parameter int  NUM_REGS = 27,
  localparam int AW       = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat,
  output logic                       all_written
);
  localparam logic [BYTE_W-1:0] LAST = BYTE_W'(NUM_REGS - 1);

  logic [BYTE_W-1:0]   regs [NUM_REGS];
  logic [NUM_REGS-1:0] written;
  logic                full_q;
  logic                in_range;

  assign in_range = (wr_addr <= LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      written     <= '0;
      full_q      <= 1'b0;
      all_written <= 1'b0;
    end else begin
      if (wr_en && in_range) begin
        regs[wr_addr[AW-1:0]]    <= wr_data;
        written[wr_addr[AW-1:0]] <= 1'b1;
      end
      full_q      <= &written;
      all_written <= (&written) & ~full_q;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*BYTE_W +: BYTE_W] = regs[g];
  end

  // R2: an in-range write lands in the addressed register
  assert_store_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_range) |=> regs[$past(wr_addr[AW-1:0])] == $past(wr_data));

  // R3: an out-of-range write touches nothing
  assert_discard_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_range) |=> $stable(regs_flat));

  // R6: the completion strobe is a single clock wide
  assert_one_shot_R6: assert property (@(posedge clk) disable iff (rst)
    all_written |=> !all_written);

  // R6: the strobe only follows a complete register set
  assert_strobe_full_R6: assert property (@(posedge clk) disable iff (rst)
    all_written |-> (&written));
endmodule

// File: rtl/status_bytes.sv
module status_bytes
  import i2c_ctl_pkg::*;
#(
  parameter int  NUM_STAT = 3,
  localparam int IDXW     = $clog2(NUM_STAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDXW-1:0]   rd_idx,
  input  logic              rd_ack,
  input  logic [IDXW-1:0]   ack_idx,
  input  logic [6:0]        core_stat0,
  input  logic [5:0]        core_stat1,
  input  logic [7:0]        core_stat2,
  input  logic [1:0]        xtal_sel,
  output logic [BYTE_W-1:0] tx_byte
);
  logic por_q;

  always_ff @(posedge clk) begin
    if (rst)                          por_q <= 1'b1;
    else if (rd_ack && ack_idx == '0) por_q <= 1'b0;
  end

  always_comb begin
    unique case (rd_idx)
      IDXW'(0): tx_byte = {por_q, core_stat0};
      IDXW'(1): tx_byte = {core_stat1, xtal_sel};
      IDXW'(2): tx_byte = core_stat2;
      default:  tx_byte = 8'hFF;
    endcase
  end

  // R5: the power flag only drops after byte 0 was acknowledged
  assert_por_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(por_q) |-> $past(rd_ack && ack_idx == '0));
endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
  import i2c_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h45,
  parameter int         NUM_REGS = 27,
  parameter int         NUM_STAT = 3,
  localparam int        IDXW     = $clog2(NUM_STAT + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  input  logic [6:0]                 core_stat0,
  input  logic [5:0]                 core_stat1,
  input  logic [7:0]                 core_stat2,
  output logic [NUM_REGS*BYTE_W-1:0] ctrl_regs,
  output logic                       all_written
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en, rd_ack;
  logic [BYTE_W-1:0] wr_addr, wr_data, tx_byte;
  logic [IDXW-1:0]   rd_idx, ack_idx;

  i2c_line_sync i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_STAT(NUM_STAT)) i_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .tx_byte(tx_byte), .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_ack(rd_ack), .ack_idx(ack_idx)
  );

  ctrl_reg_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_flat(ctrl_regs), .all_written(all_written)
  );

  status_bytes #(.NUM_STAT(NUM_STAT)) i_stat (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_ack(rd_ack),
    .ack_idx(ack_idx), .core_stat0(core_stat0), .core_stat1(core_stat1),
    .core_stat2(core_stat2), .xtal_sel(ctrl_regs[1:0]), .tx_byte(tx_byte)
  );
endmodule

// File: tb/test_i2c_ctl_slave.sv
module test_i2c_ctl_slave;
  localparam int Q = 8;
  localparam int NR = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic [6:0] core_stat0 = 7'h2A;
  logic [5:0] core_stat1 = 6'h15;
  logic [7:0] core_stat2 = 8'hC3;
  logic [NR*8-1:0] ctrl_regs;
  logic all_written;

  int n_chk = 0, n_bad = 0, n_strobe = 0;
  logic [7:0] model [NR];
  logic [7:0] exp_q [$];
  logic [7:0] obs_byte;
  event obs_ev;

  always #4 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  i2c_ctl_slave i_i2c_ctl_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .core_stat0(core_stat0), .core_stat1(core_stat1), .core_stat2(core_stat2),
    .ctrl_regs(ctrl_regs), .all_written(all_written)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && all_written) n_strobe++;

  // monitor: pops expected status bytes as reads complete
  always @(obs_ev) begin
    if (exp_q.size() == 0) check("R4 unexpected byte", {24'h0, obs_byte}, 32'hDEAD);
    else check("R4/R5 status byte", {24'h0, obs_byte}, {24'h0, exp_q.pop_front()});
  end

  task automatic qd(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_low = 0; qd(); m_scl = 1; qd(); m_low = 1; qd(); m_scl = 0; qd();
  endtask

  task automatic bus_stop();
    m_low = 1; qd(); m_scl = 1; qd(); m_low = 0; qd(); qd();
    check("R7 released after stop", {31'h0, sda_oe}, 32'h0);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qd(); m_scl = 1; qd(); qd(); m_scl = 0; qd();
    end
    m_low = 0; qd(); m_scl = 1; qd(); ack = ~sda_line; qd(); m_scl = 0; qd();
  endtask

  task automatic rbyte(input logic ack_it, output logic [7:0] b);
    m_low = 0;
    for (int i = 0; i < 8; i++) begin
      qd(); m_scl = 1; qd(); b = {b[6:0], sda_line}; qd(); m_scl = 0; qd();
    end
    m_low = ack_it; qd(); m_scl = 1; qd(); qd(); m_scl = 0; qd(); m_low = 0;
  endtask

  task automatic rd_txn(input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    wbyte(8'h8B, ack);
    check("R1 read address ack", {31'h0, ack}, 32'h1);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, b);
      obs_byte = b;
      ->obs_ev;
      qd();
    end
    bus_stop();
  endtask

  task automatic wr_txn(input logic [7:0] sub, input logic [7:0] d[$]);
    logic ack;
    bus_start();
    wbyte(8'h8A, ack);
    check("R1 write address ack", {31'h0, ack}, 32'h1);
    wbyte(sub, ack);
    check("R7 subaddress ack", {31'h0, ack}, 32'h1);
    foreach (d[i]) begin
      wbyte(d[i], ack);
      check("R3/R7 data ack", {31'h0, ack}, 32'h1);
      if (int'(sub) + i < NR) model[int'(sub) + i] = d[i];
    end
    bus_stop();
  endtask

  task automatic cmp_regs(input string req);
    for (int i = 0; i < NR; i++)
      check(req, {24'h0, ctrl_regs[i*8 +: 8]}, {24'h0, model[i]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d[$];
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 sda released", {31'h0, sda_oe}, 32'h0);
    check("R8 strobe low", {31'h0, all_written}, 32'h0);
    cmp_regs("R8 register reset");

    // R5: NACKed byte 0 keeps the flag set
    exp_q.push_back({1'b1, 7'h2A});
    rd_txn(1);
    exp_q.push_back({1'b1, 7'h2A});
    rd_txn(1);
    // R4 full order; the flag clears only after this read acks byte 0
    exp_q.push_back({1'b1, 7'h2A});
    exp_q.push_back({6'h15, 2'b00});
    exp_q.push_back(8'hC3);
    exp_q.push_back(8'hFF);
    exp_q.push_back(8'hFF);
    rd_txn(5);
    exp_q.push_back({1'b0, 7'h2A});
    rd_txn(1);

    // R1: foreign address not acknowledged, nothing stored
    bus_start();
    wbyte(8'h90, ack);
    check("R1 foreign address nack", {31'h0, ack}, 32'h0);
    wbyte(8'h00, ack);
    bus_stop();
    cmp_regs("R1 foreign address no effect");

    // R2: burst with auto-increment
    d = '{8'h03, 8'h11, 8'h22};
    wr_txn(8'h00, d);
    cmp_regs("R2 burst write");
    // R4: crystal bits echoed in byte 1, new core values
    core_stat2 = 8'h5A;
    exp_q.push_back({1'b0, 7'h2A});
    exp_q.push_back({6'h15, 2'b11});
    exp_q.push_back(8'h5A);
    rd_txn(3);

    // R3: out-of-range and test subaddress discarded
    d = '{8'h55};
    wr_txn(8'h1B, d);
    d = '{8'hAA, 8'hBB};
    wr_txn(8'hFE, d);
    cmp_regs("R3 discarded writes");
    check("R6 no strobe yet", n_strobe, 0);

    // fill 0x03..0x19, then complete at 0x1A with overflow into 0x1B
    d = {};
    for (int i = 0; i < 23; i++) d.push_back(8'(8'h30 + i));
    wr_txn(8'h03, d);
    check("R6 no strobe before last register", n_strobe, 0);
    d = '{8'h99, 8'h77};
    wr_txn(8'h1A, d);
    check("R6 single strobe on completion", n_strobe, 1);
    cmp_regs("R3 overflow byte discarded");

    // R6: rewrite does not re-pulse
    d = '{8'h01};
    wr_txn(8'h00, d);
    check("R6 no second strobe", n_strobe, 1);
    cmp_regs("R2 rewrite");

    // R8: reset restores flag and registers
    @(negedge clk) rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    cmp_regs("R8 re-reset");
    exp_q.push_back({1'b1, 7'h2A});
    rd_txn(1);

    check("R4 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule